// File: doc/BRIEF.md
# Down-Counting Interval Timer with Repeat Control

This block is a down-counting interval timer for a low-power domain. A counter steps down by one on every cycle where a slow-rate enable input is high. When it passes zero it reloads, either from compare value A or from all ones. A repeat register limits how many underflows happen before the timer halts on its own. A second pair of registers, compare B and repeat B, can serve as buffers. They feed the next top value and the next repeat count into the active registers, so the timer runs on without a gap.

Software drives the timer through a small write port: one strobe, a 3-bit address and a data word. The command word carries single-cycle start, stop and clear strobes. Four sticky event flags record matches, underflow and repeat exhaustion, and they are cleared by writing ones. Two outputs either toggle or give a one-tick pulse on each underflow. The second output is linked to the repeat buffer value.

Top module: `rpt_down_timer`

## Requirements
- R1: While running, each cycle with `tick` high and no write moves `count` down by one; a cycle with `tick` low leaves it unchanged.
- R2: An underflow is a counting step from zero. It sets flag bit 2 and reloads `count` with compare A when config bit 0 is set, or with 0xFFFF when it is clear. When config bit 1 (buffer) is also set, it reloads with compare B instead, and compare B is copied into compare A.
- R3: A write to address 1 loads `count` with the data; addresses 2, 3, 4, 5 load compare A, compare B, repeat A and repeat B; address 6 is the config (bit0 top from compare A, bit1 buffer, bit2 pulse mode).
- R4: A command write (address 0) with bit 0 or a high `ext_start` starts the timer. Bit 1 stops it, and stop wins when both are present.
- R5: Command bit 2 sets `count` to zero. When it comes together with a start, `count` is loaded with the top value instead, and the timer runs.
- R6: When repeat A is nonzero, each underflow decrements it. An underflow with repeat A equal to one sets flag bit 3 and stops the timer, unless the buffer is on and repeat B is nonzero.
- R7: When the buffer is on and repeat A runs out, repeat B is copied into repeat A and the timer keeps running. Repeat A equal to zero means free-running.
- R8: Flag bit 0 sets when a counting step gives a `count` equal to compare A, and bit 1 when it equals compare B. Flags stay set until a write to address 7 has a one in the matching bit.
- R9: In toggle mode (config bit 2 = 0), `out0` inverts on each underflow. In pulse mode it goes high on an underflow and low on the next tick without an underflow.
- R10: `out1` behaves like `out0` while repeat B is nonzero and is held low while repeat B is zero.
- R11: While stopped, `tick` has no effect on `count`.
- R12: After reset, `count`, `running`, `flags`, `out0` and `out1` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow-rate counting enable |
| ext_start | input | 1 | External start pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| count | output | 16 | Counter value |
| running | output | 1 | Timer is counting |
| flags | output | 4 | Sticky flags: 0 match A, 1 match B, 2 underflow, 3 repeat exhausted |
| out0 | output | 1 | Primary output |
| out1 | output | 1 | Linked output |

## Verification
The bench sends start and stop in the same write. A design that gives start priority would be left running. It issues clear together with start and expects the top value rather than zero. A design that treats clear as dominant would start from zero and underflow at once. It runs the repeat count out with and without the buffer. A wrong design would either never stop or halt even though a nonzero buffered count is waiting. Pulse-mode width and the repeat-B gating of `out1` are checked tick by tick, so a pulse held too long or an ungated second output is caught.

// File: rtl/rpt_timer_pkg.sv
package rpt_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CMD  = 3'd0,
    ADR_CNT  = 3'd1,
    ADR_CMPA = 3'd2,
    ADR_CMPB = 3'd3,
    ADR_RPTA = 3'd4,
    ADR_RPTB = 3'd5,
    ADR_CFG  = 3'd6,
    ADR_FCLR = 3'd7
  } reg_addr_e;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_CLEAR = 2;

  localparam int CFG_TOP   = 0;
  localparam int CFG_BUF   = 1;
  localparam int CFG_PULSE = 2;

  localparam int FL_MATCHA = 0;
  localparam int FL_MATCHB = 1;
  localparam int FL_UNDER  = 2;
  localparam int FL_REPZ   = 3;

  typedef struct packed {
    logic pulse;
    logic buffered;
    logic top_en;
  } cfg_t;
endpackage

// File: rtl/rpt_timer_regs.sv
module rpt_timer_regs
  import rpt_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             uf,
  output logic [CNT_W-1:0] cmpa_q,
  output logic [CNT_W-1:0] cmpb_q,
  output logic [REP_W-1:0] rpta_q,
  output logic [REP_W-1:0] rptb_q,
  output cfg_t             cfg_q
);
  localparam logic [REP_W-1:0] REP_ONE = REP_W'(1);

  logic wr_cmpa, wr_cmpb, wr_rpta, wr_rptb, wr_cfg;
  assign wr_cmpa = wr_en && (wr_addr == ADR_CMPA);
  assign wr_cmpb = wr_en && (wr_addr == ADR_CMPB);
  assign wr_rpta = wr_en && (wr_addr == ADR_RPTA);
  assign wr_rptb = wr_en && (wr_addr == ADR_RPTB);
  assign wr_cfg  = wr_en && (wr_addr == ADR_CFG);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpa_q <= '0;
      cmpb_q <= '0;
      rpta_q <= '0;
      rptb_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_cmpa)
        cmpa_q <= wr_data;
      else if (uf && cfg_q.buffered)
        cmpa_q <= cmpb_q;

      if (wr_cmpb)
        cmpb_q <= wr_data;

      if (wr_rpta)
        rpta_q <= wr_data[REP_W-1:0];
      else if (uf && (rpta_q != '0)) begin
        if (rpta_q == REP_ONE)
          rpta_q <= cfg_q.buffered ? rptb_q : '0;
        else
          rpta_q <= rpta_q - REP_ONE;
      end

      if (wr_rptb)
        rptb_q <= wr_data[REP_W-1:0];

      if (wr_cfg)
        cfg_q <= cfg_t'(wr_data[2:0]);
    end
  end
endmodule

// File: rtl/rpt_timer_core.sv
module rpt_timer_core
  import rpt_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic             clr_cmd,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_val,
  input  cfg_t             cfg,
  input  logic [CNT_W-1:0] cmpa,
  input  logic [CNT_W-1:0] cmpb,
  input  logic [REP_W-1:0] rpta,
  input  logic [REP_W-1:0] rptb,
  output logic [CNT_W-1:0] cnt_q,
  output logic             running_q,
  output logic             uf,
  output logic             hit_a,
  output logic             hit_b,
  output logic             rep_out
);
  localparam logic [REP_W-1:0] REP_ONE = REP_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] top_val;
  logic [CNT_W-1:0] reload_val;
  logic             adv;
  logic             halt;

  assign top_val    = cfg.top_en ? cmpa : '1;
  assign reload_val = cfg.top_en ? (cfg.buffered ? cmpb : cmpa) : '1;

  always_comb begin
    cnt_d = cnt_q;
    adv   = 1'b0;
    uf    = 1'b0;
    if (clr_cmd) begin
      cnt_d = start_cmd ? top_val : '0;
    end else if (cnt_wr) begin
      cnt_d = wr_val;
    end else if (running_q && tick && !stop_cmd) begin
      adv = 1'b1;
      if (cnt_q == '0) begin
        uf    = 1'b1;
        cnt_d = reload_val;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign rep_out = uf && (rpta == REP_ONE);
  assign halt    = rep_out && !(cfg.buffered && (rptb != '0));
  assign hit_a   = adv && (cnt_d == cmpa);
  assign hit_b   = adv && (cnt_d == cmpb);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (stop_cmd)
        running_q <= 1'b0;
      else if (start_cmd)
        running_q <= 1'b1;
      else if (halt)
        running_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rpt_timer_flags.sv
module rpt_timer_flags
  import rpt_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_vec,
  input  logic             clr_wr,
  input  logic [NFLAG-1:0] clr_mask,
  output logic [NFLAG-1:0] flags_q
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags_q[i] <= 1'b0;
      else if (set_vec[i])
        flags_q[i] <= 1'b1;
      else if (clr_wr && clr_mask[i])
        flags_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rpt_timer_outs.sv
module rpt_timer_outs #(
  parameter int NOUT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            uf,
  input  logic            pulse_mode,
  input  logic [NOUT-1:0] ch_en,
  output logic [NOUT-1:0] out_q
);
  for (genvar c = 0; c < NOUT; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst || !ch_en[c])
        out_q[c] <= 1'b0;
      else if (pulse_mode) begin
        if (uf)
          out_q[c] <= 1'b1;
        else if (tick)
          out_q[c] <= 1'b0;
      end else if (uf)
        out_q[c] <= ~out_q[c];
    end
  end
endmodule

// File: rtl/rpt_down_timer.sv
module rpt_down_timer
  import rpt_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ext_start,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              running,
  output logic [NFLAG-1:0]  flags,
  output logic              out0,
  output logic              out1
);
  logic cmd_wr, start_cmd, stop_cmd, clr_cmd, cnt_wr, fclr_wr;
  logic uf, hit_a, hit_b, rep_out;
  logic [CNT_W-1:0] cmpa, cmpb;
  logic [REP_W-1:0] rpta, rptb;
  cfg_t             cfg;
  logic [NFLAG-1:0] set_vec;
  logic [1:0]       ch_en;
  logic [1:0]       outs;

  assign cmd_wr    = wr_en && (wr_addr == ADR_CMD);
  assign start_cmd = (cmd_wr && wr_data[CMD_START]) || ext_start;
  assign stop_cmd  = cmd_wr && wr_data[CMD_STOP];
  assign clr_cmd   = cmd_wr && wr_data[CMD_CLEAR];
  assign cnt_wr    = wr_en && (wr_addr == ADR_CNT);
  assign fclr_wr   = wr_en && (wr_addr == ADR_FCLR);

  rpt_timer_regs #(.CNT_W(CNT_W), .REP_W(REP_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .uf(uf), .cmpa_q(cmpa), .cmpb_q(cmpb), .rpta_q(rpta), .rptb_q(rptb),
    .cfg_q(cfg)
  );

  rpt_timer_core #(.CNT_W(CNT_W), .REP_W(REP_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .start_cmd(start_cmd),
    .stop_cmd(stop_cmd), .clr_cmd(clr_cmd), .cnt_wr(cnt_wr), .wr_val(wr_data),
    .cfg(cfg), .cmpa(cmpa), .cmpb(cmpb), .rpta(rpta), .rptb(rptb),
    .cnt_q(count), .running_q(running), .uf(uf), .hit_a(hit_a),
    .hit_b(hit_b), .rep_out(rep_out)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FL_MATCHA] = hit_a;
    set_vec[FL_MATCHB] = hit_b;
    set_vec[FL_UNDER]  = uf;
    set_vec[FL_REPZ]   = rep_out;
  end

  rpt_timer_flags u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_wr(fclr_wr),
    .clr_mask(wr_data[NFLAG-1:0]), .flags_q(flags)
  );

  assign ch_en = {(rptb != '0), 1'b1};

  rpt_timer_outs #(.NOUT(2)) u_outs (
    .clk(clk), .rst(rst), .tick(tick), .uf(uf), .pulse_mode(cfg.pulse),
    .ch_en(ch_en), .out_q(outs)
  );

  assign out0 = outs[0];
  assign out1 = outs[1];
endmodule

// File: rtl/rpt_down_timer_chk.sv
module rpt_down_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic [3:0]       flags
);
  assert_step_down_R1: assert property (@(posedge clk) disable iff (rst)
    (running && tick && !wr_en && count != '0) |=> (count == $past(count) - 1'b1));

  assert_underflow_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (running && tick && !wr_en && count == '0) |=> flags[2]);

  assert_stop_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0 && wr_data[1]) |=> !running);

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0 && wr_data[2] && !wr_data[0]) |=> (count == '0));

  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> ((flags & $past(flags)) == $past(flags)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!running && !wr_en) |=> $stable(count));
endmodule

bind rpt_down_timer rpt_down_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .count(count), .running(running), .flags(flags)
);

// File: tb/rpt_down_timer_bench.sv
module rpt_down_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        ext_start = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        running;
  logic [3:0]  flags;
  logic        out0, out1;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  rpt_down_timer u_rpt_down_timer (
    .clk(clk), .rst(rst), .tick(tick), .ext_start(ext_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .running(running), .flags(flags),
    .out0(out0), .out1(out1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; tick = 1'b0; ext_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R12 count", count, 0);
    check("R12 running", running, 0);
    check("R12 flags", flags, 0);
    check("R12 outs", {out1, out0}, 0);
  endtask

  task automatic t_count();
    do_reset();
    wr(3'd6, 16'h0001);
    wr(3'd2, 16'd4);
    wr(3'd3, 16'd1);
    wr(3'd1, 16'd2);
    check("R3 count write", count, 2);
    wr(3'd0, 16'h0001);
    check("R4 start", running, 1);
    @(negedge clk); @(negedge clk);
    check("R1 no tick hold", count, 2);
    step();
    check("R1 step", count, 1);
    check("R8 match B", flags, 4'b0010);
    step();
    check("R1 step to zero", count, 0);
    step();
    check("R2 reload from compare A", count, 4);
    check("R2 R8 flags", flags, 4'b0111);
    @(negedge clk); @(negedge clk);
    check("R8 sticky", flags, 4'b0111);
    wr(3'd7, 16'h0005);
    check("R8 partial clear", flags, 4'b0010);
    wr(3'd7, 16'h000F);
    check("R8 full clear", flags, 0);
  endtask

  task automatic t_nottop();
    do_reset();
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h0001);
    step();
    check("R2 reload all ones", count, 16'hFFFF);
  endtask

  task automatic t_cmds();
    do_reset();
    wr(3'd1, 16'd7);
    wr(3'd0, 16'h0003);
    check("R4 stop wins from idle", running, 0);
    step();
    check("R11 idle tick ignored", count, 7);
    wr(3'd0, 16'h0001);
    check("R4 start alone", running, 1);
    wr(3'd0, 16'h0003);
    check("R4 stop wins while running", running, 0);
    wr(3'd0, 16'h0004);
    check("R5 clear", count, 0);
    check("R5 clear keeps stopped", running, 0);
    wr(3'd6, 16'h0001);
    wr(3'd2, 16'd9);
    wr(3'd0, 16'h0005);
    check("R5 clear+start top", count, 9);
    check("R5 clear+start running", running, 1);
    wr(3'd0, 16'h0002);
    @(negedge clk);
    ext_start = 1'b1;
    @(negedge clk);
    ext_start = 1'b0;
    check("R4 external start", running, 1);
  endtask

  task automatic t_repeat();
    do_reset();
    wr(3'd6, 16'h0001);
    wr(3'd2, 16'd1);
    wr(3'd4, 16'd2);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h0001);
    step();
    check("R6 first underflow runs", running, 1);
    check("R6 no repeat flag yet", flags[3], 0);
    step();
    step();
    check("R6 stops after count", running, 0);
    check("R6 repeat flag", flags[3], 1);
    check("R6 reloaded value", count, 1);
  endtask

  task automatic t_buffer();
    do_reset();
    wr(3'd6, 16'h0003);
    wr(3'd2, 16'd1);
    wr(3'd3, 16'd3);
    wr(3'd4, 16'd1);
    wr(3'd5, 16'd2);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h0001);
    step();
    check("R2 buffered top reload", count, 3);
    check("R7 keeps running", running, 1);
    check("R7 repeat flag", flags[3], 1);
    for (int i = 0; i < 8; i++) step();
    check("R7 runs on from buffer", running, 1);
    check("R2 buffered period", count, 3);
  endtask

  task automatic t_outs();
    do_reset();
    wr(3'd6, 16'h0001);
    wr(3'd2, 16'd1);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h0001);
    step();
    check("R9 toggle high", out0, 1);
    check("R10 out1 gated", out1, 0);
    step();
    check("R9 hold between", out0, 1);
    step();
    check("R9 toggle low", out0, 0);
    wr(3'd5, 16'd1);
    step();
    step();
    check("R9 toggle again", out0, 1);
    check("R10 out1 active", out1, 1);
    do_reset();
    wr(3'd6, 16'h0005);
    wr(3'd2, 16'd1);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h0001);
    step();
    check("R9 pulse high", out0, 1);
    check("R10 pulse out1 gated", out1, 0);
    step();
    check("R9 pulse low", out0, 0);
  endtask

  initial begin
    t_reset();
    t_count();
    t_nottop();
    t_cmds();
    t_repeat();
    t_buffer();
    t_outs();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule